// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

This block models a row of device interface nodes that share a single interrupt-request line. Each node keeps two bits: an interrupt-enable bit and a pending-interrupt status bit. A node raises the shared request whenever both of its bits are set. The processor answers an active request with an acknowledge. That acknowledge enters node 0, the node nearest the processor, and travels down the chain through combinational logic.

A node that is not requesting hands the acknowledge on to the next node. The first requesting node the acknowledge meets keeps it. That node puts its own identification code on the code bus. On the following clock edge, its pending bit clears. Priority therefore follows position, and node 0 ranks highest. Each node's code is computed as `CODE_BASE` plus its position, `CODE_W` bits wide. The processor side uses this code as part of the service-routine address.

Top module: `irq_chain`

## Requirements
- R1: A synchronous reset clears every enable bit and every pending bit. After reset, `intr` is 0 and `code_bus` is 0. In that state `ack_tail` follows `inta`.
- R2: `intr` is 1 exactly when at least one node has both its pending bit and its enable bit set.
- R3: A 1 on `irq_set[i]` sets the pending bit of node i at the next clock edge. A 1 on `ie_wr` loads `ie_data` into the enable bits at that same edge. A pending bit whose enable bit is 0 stays pending but does not drive `intr`. It reaches `intr` once its enable bit is written to 1.
- R4: While `inta` is 1, the requesting node with the lowest index takes the acknowledge, because node 0 is nearest the processor.
- R5: While `inta` is 1 and a node takes the acknowledge, `code_bus` equals `CODE_BASE` plus that node's index, truncated to `CODE_W` bits. While `inta` is 0, `code_bus` is 0.
- R6: A node that is not requesting forwards the acknowledge. This holds even when its pending bit is set but its enable bit is 0. When `inta` is 1 and no node is requesting, `ack_tail` is 1 and `code_bus` is 0. Otherwise `ack_tail` is 0.
- R7: The pending bit of the node that took the acknowledge clears at the next clock edge. All other pending bits keep their values.
- R8: If `irq_set[i]` is 1 in the same cycle that node i takes the acknowledge, its pending bit stays 1.
- R9: At most one node takes the acknowledge in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ie_wr | input | 1 | Load `ie_data` into the enable bits |
| ie_data | input | NODES | New enable bits, one per node |
| irq_set | input | NODES | Per-node pulse that sets the pending bit |
| inta | input | 1 | Acknowledge from the processor, enters node 0 |
| intr | output | 1 | Shared interrupt-request line |
| code_bus | output | CODE_W | Identification code of the node holding the acknowledge, 0 otherwise |
| ack_tail | output | 1 | Acknowledge leaving the last node unclaimed |

## Verification
The bench sweeps every combination of pending bits and enable bits on a 4-node chain. For each combination it acknowledges twice. It checks that the first acknowledge goes to the lowest requesting index and the second to the next one. A chain that resolved priority from the far end, or that let a pending-but-disabled node grab the acknowledge, would return the wrong code. A design that cleared the wrong pending bit, or all of them, would show the wrong second code or a wrong `intr`. Directed cases then cover a set arriving in the same cycle as the acknowledge, which a clear-wins design would lose. They also cover a disabled request being released by a later enable write, and an acknowledge sent with nothing pending, which must leave the chain at `ack_tail` with a zero code.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Identification code of a node: base value plus position in the chain.
  function automatic int node_code(input int base, input int pos);
    return base + pos;
  endfunction
endpackage

// File: rtl/irqc_node.sv
module irqc_node #(
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ie_wr,
  input  logic              ie_d,
  input  logic              irq_set,
  input  logic              ack_in,
  output logic              ack_out,
  output logic              req,
  output logic              take,
  output logic [CODE_W-1:0] code_o
);
  logic ie_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ie_wr) ie_q <= ie_d;
      if (irq_set)   irq_q <= 1'b1;
      else if (take) irq_q <= 1'b0;
    end
  end

  assign req     = irq_q & ie_q;
  assign take    = ack_in & req;
  assign ack_out = ack_in & ~req;
  assign code_o  = take ? CODE : '0;
endmodule

// File: rtl/irqc_code_or.sv
module irqc_code_or #(
  parameter int NODES  = 4,
  parameter int CODE_W = 6
) (
  input  logic [NODES*CODE_W-1:0] codes,
  output logic [CODE_W-1:0]       bus
);
  always_comb begin
    bus = '0;
    for (int k = 0; k < NODES; k++) bus = bus | codes[k*CODE_W +: CODE_W];
  end
endmodule

// File: rtl/irq_chain.sv
module irq_chain #(
  parameter int NODES     = 4,
  parameter int CODE_W    = 6,
  parameter int CODE_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ie_wr,
  input  logic [NODES-1:0]  ie_data,
  input  logic [NODES-1:0]  irq_set,
  input  logic              inta,
  output logic              intr,
  output logic [CODE_W-1:0] code_bus,
  output logic              ack_tail
);
  localparam int CW = NODES * CODE_W;

  logic [NODES:0]    ack_link;
  logic [NODES-1:0]  req;
  logic [NODES-1:0]  take;
  logic [CW-1:0]     codes;

  assign ack_link[0] = inta;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    localparam logic [CODE_W-1:0] NC = CODE_W'(irqc_pkg::node_code(CODE_BASE, i));
    irqc_node #(.CODE_W(CODE_W), .CODE(NC)) u_node (
      .clk     (clk),
      .rst     (rst),
      .ie_wr   (ie_wr),
      .ie_d    (ie_data[i]),
      .irq_set (irq_set[i]),
      .ack_in  (ack_link[i]),
      .ack_out (ack_link[i+1]),
      .req     (req[i]),
      .take    (take[i]),
      .code_o  (codes[i*CODE_W +: CODE_W])
    );
  end

  irqc_code_or #(.NODES(NODES), .CODE_W(CODE_W)) u_or (
    .codes (codes),
    .bus   (code_bus)
  );

  assign intr     = |req;
  assign ack_tail = ack_link[NODES];
endmodule

// File: rtl/irqc_check.sv
module irqc_check #(
  parameter int NODES  = 4,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              inta,
  input logic              intr,
  input logic              ack_tail,
  input logic [CODE_W-1:0] code_bus,
  input logic [NODES-1:0]  irq_set,
  input logic [NODES-1:0]  req,
  input logic [NODES-1:0]  take
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !intr);

  assert_code_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !inta |-> code_bus == '0);

  assert_tail_only_unclaimed_R6: assert property (@(posedge clk) disable iff (rst)
    ack_tail |-> (inta && !intr));

  assert_tail_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (inta && intr) |-> !ack_tail);

  assert_single_taker_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take));

  assert_taker_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (inta && irq_set == '0) |=> (req & $past(take)) == '0);
endmodule

bind irq_chain irqc_check #(.NODES(NODES), .CODE_W(CODE_W)) u_irqc_check (
  .clk      (clk),
  .rst      (rst),
  .inta     (inta),
  .intr     (intr),
  .ack_tail (ack_tail),
  .code_bus (code_bus),
  .irq_set  (irq_set),
  .req      (req),
  .take     (take)
);

// File: tb/test_irq_chain.sv
`timescale 1ns/1ps
module test_irq_chain;
  localparam int N    = 4;
  localparam int W    = 6;
  localparam int BASE = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ie_wr = 1'b0;
  logic [N-1:0] ie_data = '0;
  logic [N-1:0] irq_set = '0;
  logic         inta = 1'b0;
  logic         intr;
  logic [W-1:0] code_bus;
  logic         ack_tail;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_chain #(.NODES(N), .CODE_W(W), .CODE_BASE(BASE)) i_irq_chain (
    .clk(clk), .rst(rst), .ie_wr(ie_wr), .ie_data(ie_data), .irq_set(irq_set),
    .inta(inta), .intr(intr), .code_bus(code_bus), .ack_tail(ack_tail)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [N-1:0] r);
    for (int k = 0; k < N; k++) if (r[k]) return (BASE + k) % (1 << W);
    return 0;
  endfunction

  function automatic logic [N-1:0] drop_low(input logic [N-1:0] r);
    return r & (r - 1'b1);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; ie_wr = 1'b0; irq_set = '0; inta = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    do_reset();
    #1;
    chk("R1 intr", int'(intr), 0);
    chk("R1 code", int'(code_bus), 0);
    inta = 1'b1; #1;
    chk("R1 tail", int'(ack_tail), 1);
    inta = 1'b0;

    for (int iv = 0; iv < (1 << N); iv++) begin
      for (int ev = 0; ev < (1 << N); ev++) begin
        logic [N-1:0] r;
        logic [N-1:0] r2;
        r  = N'(iv & ev);
        r2 = drop_low(r);
        do_reset();
        ie_wr = 1'b1; ie_data = N'(ev); irq_set = N'(iv);
        @(negedge clk); ie_wr = 1'b0; irq_set = '0; #1;
        chk("R2 intr", int'(intr), int'(r != 0));
        chk("R5 code idle", int'(code_bus), 0);
        inta = 1'b1; #1;
        chk("R4 first code", int'(code_bus), exp_code(r));
        chk("R6 tail", int'(ack_tail), int'(r == 0));
        @(negedge clk); inta = 1'b0; #1;
        chk("R7 intr after take", int'(intr), int'(r2 != 0));
        inta = 1'b1; #1;
        chk("R7 second code", int'(code_bus), exp_code(r2));
        @(negedge clk); inta = 1'b0;
      end
    end

    // R3: pending but disabled request held, released by enable write
    do_reset();
    irq_set = 4'b0010;
    @(negedge clk); irq_set = '0; inta = 1'b1; #1;
    chk("R3 disabled no intr", int'(intr), 0);
    chk("R6 disabled passes", int'(ack_tail), 1);
    @(negedge clk); inta = 1'b0; ie_wr = 1'b1; ie_data = 4'b0010;
    @(negedge clk); ie_wr = 1'b0; #1;
    chk("R3 enabled intr", int'(intr), 1);
    inta = 1'b1; #1;
    chk("R3 code", int'(code_bus), BASE + 1);
    @(negedge clk); inta = 1'b0;

    // R8: set in same cycle as take keeps the bit
    do_reset();
    ie_wr = 1'b1; ie_data = 4'b1111; irq_set = 4'b0100;
    @(negedge clk); ie_wr = 1'b0; irq_set = 4'b0100; inta = 1'b1; #1;
    chk("R8 code", int'(code_bus), BASE + 2);
    @(negedge clk); inta = 1'b0; irq_set = '0; #1;
    chk("R8 still pending", int'(intr), 1);
    inta = 1'b1; #1;
    chk("R8 code again", int'(code_bus), BASE + 2);
    @(negedge clk); inta = 1'b0; #1;
    chk("R7 cleared", int'(intr), 0);
    chk("R9 code idle", int'(code_bus), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule